// File: doc/BRIEF.md
# Histogram Bin Accumulator

The block builds a histogram of a sample stream inside a dual-port synchronous RAM. Each clock it may take one bin index and add one to the count stored at that index. The RAM returns read data one clock after the address is given, so the block splits each update into a read, an increment and a delayed write. One port reads the old count and the other writes the new one, so a fresh update can enter every cycle. When the same bin comes back before its earlier write has settled into the RAM, the increment takes its input from the newest pending write rather than from the stale RAM word.

Counts stop at the largest value their width can hold. A clear request, and reset as well, sets every bin to zero by walking the addresses one per clock. While the walk runs a busy flag is high and samples are dropped. A host reads a bin through a separate address input and gets the count one cycle later. Host reads are valid only when no sample is being offered and the last accepted sample is at least three cycles old.

Top module: `hist_binner`

## Requirements
- R1: After reset is released, `busy` is high in the first cycle.
- R2: Each accepted sample (`smp_valid` high, `busy` low, `clr_req` low) raises the count of bin `smp_bin` by exactly one. Bins not named are unchanged.
- R3: Samples to one bin on consecutive cycles, for any run length, are all counted.
- R4: A bin that repeats with one other sample between its two uses is counted correctly.
- R5: A count that holds 2^CNT_W-1 stays at that value on further samples and never wraps to zero.
- R6: A `clr_req` pulse while idle holds `busy` high for exactly NUM_BINS cycles, starting the cycle after the pulse. The walk writes zero to addresses 0 to NUM_BINS-1 in ascending order, and afterwards every bin reads zero.
- R7: Samples offered in the same cycle as `clr_req`, or while `busy` is high, have no effect on any count.
- R8: `host_data` shows the count of the bin given on `host_addr` one clock edge earlier. It keeps the previous result until that edge.
- R9: Reset starts a clear walk of NUM_BINS cycles, so all bins read zero once `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; starts a clear walk |
| smp_valid | input | 1 | A sample is offered this cycle |
| smp_bin | input | BIN_W | Bin index of the offered sample |
| clr_req | input | 1 | Request to zero all bins |
| busy | output | 1 | Clear walk in progress; samples dropped |
| host_addr | input | BIN_W | Bin the host wants to read |
| host_data | output | CNT_W | Count of the bin addressed one cycle earlier |

## Verification
The hardest case to reach is a repeat of a bin exactly two cycles after its first use. In that case the RAM read and the pending write hit the same word on the same edge, and only the second forwarding stage holds the right count. The stimulus table places alternating bins back to back to create distance-one and distance-two repeats. A pseudo-random stream then adds long single-bin runs mixed with idle gaps. Saturation is driven by a run longer than the count range, and a clear is issued with samples offered in the same cycle and throughout the walk.

// File: rtl/hist_pkg.sv
package hist_pkg;

    // Clear walker states
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_st_e;

    // Write-back stages that can still disagree with a RAM readback:
    // the write being issued and the write that landed on the read edge.
    localparam int WB_DEPTH = 2;

endpackage

// File: rtl/hist_ram.sv
module hist_ram #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Read port, one cycle latency, old data on a same-edge collision
    always_ff @(posedge clk) begin
        rdata <= mem_q[raddr];
    end

endmodule

// File: rtl/hist_clr_walk.sv
module hist_clr_walk
    import hist_pkg::*;
#(
    parameter int NUM_BINS = 16,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    output logic              busy,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BINS - 1);

    walk_st_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= WALK_RUN;
            addr <= '0;
        end else begin
            case (st_q)
                WALK_IDLE: begin
                    if (req) begin
                        st_q <= WALK_RUN;
                        addr <= '0;
                    end
                end
                WALK_RUN: begin
                    if (addr == LAST_ADDR) begin
                        st_q <= WALK_IDLE;
                    end else begin
                        addr <= addr + 1'b1;
                    end
                end
                default: st_q <= WALK_IDLE;
            endcase
        end
    end

    assign busy = (st_q == WALK_RUN);

endmodule

// File: rtl/hist_upd_pipe.sv
module hist_upd_pipe
    import hist_pkg::*;
#(
    parameter int BIN_W = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_vld,
    input  logic [BIN_W-1:0] in_bin,
    input  logic [CNT_W-1:0] rd_q,
    output logic             wr_en,
    output logic [BIN_W-1:0] wr_addr,
    output logic [CNT_W-1:0] wr_data
);

    typedef struct packed {
        logic             vld;
        logic [BIN_W-1:0] bin;
        logic [CNT_W-1:0] cnt;
    } wb_stage_t;

    // Read stage: address went to the RAM, data returns now
    logic             s1_vld;
    logic [BIN_W-1:0] s1_bin;

    // Write-back stages: [0] is being written, [1] was written on the
    // same edge that captured the current readback
    wb_stage_t wb_q [WB_DEPTH];

    logic [CNT_W-1:0] base_cnt;
    logic [CNT_W-1:0] next_cnt;

    // Forwarding: scan oldest to newest so the newest match wins
    always_comb begin
        base_cnt = rd_q;
        for (int i = WB_DEPTH - 1; i >= 0; i--) begin
            if (wb_q[i].vld && (wb_q[i].bin == s1_bin)) begin
                base_cnt = wb_q[i].cnt;
            end
        end
    end

    // Saturating increment
    always_comb begin
        if (base_cnt == {CNT_W{1'b1}}) begin
            next_cnt = base_cnt;
        end else begin
            next_cnt = base_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            s1_vld <= 1'b0;
            s1_bin <= '0;
        end else begin
            s1_vld <= in_vld;
            s1_bin <= in_bin;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wb_q[0] <= '0;
        end else begin
            wb_q[0].vld <= s1_vld;
            wb_q[0].bin <= s1_bin;
            wb_q[0].cnt <= next_cnt;
        end
    end

    for (genvar g = 1; g < WB_DEPTH; g++) begin : g_wb_shift
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                wb_q[g] <= '0;
            end else begin
                wb_q[g] <= wb_q[g-1];
            end
        end
    end

    assign wr_en   = wb_q[0].vld;
    assign wr_addr = wb_q[0].bin;
    assign wr_data = wb_q[0].cnt;

endmodule

// File: rtl/hist_binner.sv
module hist_binner
    import hist_pkg::*;
#(
    parameter int NUM_BINS = 16,
    parameter int CNT_W    = 8,
    localparam int BIN_W   = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [BIN_W-1:0] smp_bin,
    input  logic             clr_req,
    output logic             busy,
    input  logic [BIN_W-1:0] host_addr,
    output logic [CNT_W-1:0] host_data
);

    logic             accept;
    logic             flush;
    logic [BIN_W-1:0] ram_raddr;
    logic [CNT_W-1:0] ram_rdata;
    logic             ram_we;
    logic [BIN_W-1:0] ram_waddr;
    logic [CNT_W-1:0] ram_wdata;

    logic             upd_we;
    logic [BIN_W-1:0] upd_addr;
    logic [CNT_W-1:0] upd_data;
    logic [BIN_W-1:0] walk_addr;

    assign accept    = smp_valid && !busy && !clr_req;
    assign flush     = busy || clr_req;
    assign ram_raddr = accept ? smp_bin : host_addr;

    hist_clr_walk #(
        .NUM_BINS (NUM_BINS),
        .ADDR_W   (BIN_W)
    ) walk_i (
        .clk  (clk),
        .rst  (rst),
        .req  (clr_req),
        .busy (busy),
        .addr (walk_addr)
    );

    hist_upd_pipe #(
        .BIN_W (BIN_W),
        .CNT_W (CNT_W)
    ) pipe_i (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .in_vld  (accept),
        .in_bin  (smp_bin),
        .rd_q    (ram_rdata),
        .wr_en   (upd_we),
        .wr_addr (upd_addr),
        .wr_data (upd_data)
    );

    // Write port owner: the clear walk while busy, the pipeline otherwise
    always_comb begin
        if (busy) begin
            ram_we    = 1'b1;
            ram_waddr = walk_addr;
            ram_wdata = '0;
        end else begin
            ram_we    = upd_we;
            ram_waddr = upd_addr;
            ram_wdata = upd_data;
        end
    end

    hist_ram #(
        .DEPTH  (NUM_BINS),
        .ADDR_W (BIN_W),
        .DATA_W (CNT_W)
    ) ram_i (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    assign host_data = ram_rdata;

endmodule

// File: rtl/hist_binner_chk.sv
module hist_binner_chk #(
    parameter int NUM_BINS = 16,
    parameter int BIN_W    = 4,
    parameter int CNT_W    = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             ram_we,
    input logic [BIN_W-1:0] ram_waddr,
    input logic [CNT_W-1:0] ram_wdata
);

    localparam int RUN_W = $clog2(NUM_BINS + 1) + 2;

    // Length of the busy run that just ended
    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R1
    reset_walk_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> busy);

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ram_we && ram_wdata == '0));

    // R6
    clear_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && run_len != '0) |-> (run_len == RUN_W'(NUM_BINS)));

    // R6
    walk_order_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst)) |->
            (ram_waddr == BIN_W'($past(ram_waddr) + 1'b1)));

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_we && !busy) |-> (ram_wdata != '0));

endmodule

bind hist_binner hist_binner_chk #(
    .NUM_BINS (NUM_BINS),
    .BIN_W    (BIN_W),
    .CNT_W    (CNT_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata)
);

// File: tb/hist_binner_tb_top.sv
`timescale 1ns/1ps
module hist_binner_tb_top;

    localparam int NB    = 16;
    localparam int BW    = 4;
    localparam int CW    = 8;
    localparam int MAXC  = (1 << CW) - 1;
    localparam int NVEC  = 12;

    // Each entry: {bin[3:0], run length[7:0]} applied back to back
    localparam logic [11:0] VEC_TBL [NVEC] = '{
        {4'd2,  8'd1}, {4'd7,  8'd1}, {4'd2,  8'd1}, {4'd7,  8'd1},
        {4'd2,  8'd1}, {4'd9,  8'd3}, {4'd9,  8'd1}, {4'd4,  8'd20},
        {4'd11, 8'd2}, {4'd4,  8'd1}, {4'd0,  8'd1}, {4'd15, 8'd5}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [BW-1:0] smp_bin = '0;
    logic          clr_req = 1'b0;
    logic          busy;
    logic [BW-1:0] host_addr = '0;
    logic [CW-1:0] host_data;

    int n_checks = 0;
    int n_fails  = 0;
    int ref_cnt [NB];
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hist_binner #(.NUM_BINS(NB), .CNT_W(CW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_bin   (smp_bin),
        .clr_req   (clr_req),
        .busy      (busy),
        .host_addr (host_addr),
        .host_data (host_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int b);
        smp_valid = 1'b1;
        smp_bin   = BW'(b);
        if (ref_cnt[b] < MAXC) ref_cnt[b]++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        smp_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic read_bin(input int b, output int v);
        smp_valid = 1'b0;
        host_addr = BW'(b);
        @(negedge clk);
        v = int'(host_data);
    endtask

    task automatic check_all(input string req);
        int v;
        idle(4);
        for (int b = 0; b < NB; b++) begin
            read_bin(b, v);
            check(req, v, ref_cnt[b]);
        end
    endtask

    task automatic wait_walk(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        int v;
        logic [15:0] lfsr;
        int cur;

        for (int b = 0; b < NB; b++) ref_cnt[b] = 0;

        // Reset
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 busy after reset", int'(busy), 1);
        wait_walk(n);
        check("R9 reset walk length", n, NB);
        check_all("R9 bins zero after reset");

        // Table of back-to-back runs, distance 1 and distance 2 repeats
        for (int i = 0; i < NVEC; i++) begin
            for (int k = 0; k < int'(VEC_TBL[i][7:0]); k++) begin
                send(int'(VEC_TBL[i][11:8]));
            end
        end
        check_all("R2 R3 R4 table stream");

        // Host read latency: bins 4 and 2 hold different counts
        idle(4);
        read_bin(4, v);
        check("R8 read bin 4", v, ref_cnt[4]);
        host_addr = BW'(2);
        check("R8 old value held before edge", int'(host_data), ref_cnt[4]);
        @(negedge clk);
        check("R8 new value after one edge", int'(host_data), ref_cnt[2]);

        // Clear with samples in the request cycle and during the walk
        smp_valid = 1'b1;
        smp_bin   = BW'(3);
        clr_req   = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        wait_walk(n);
        smp_valid = 1'b0;
        check("R6 clear walk length", n, NB);
        for (int b = 0; b < NB; b++) ref_cnt[b] = 0;
        idle(2);
        read_bin(3, v);
        check("R7 bin 3 unchanged by dropped samples", v, 0);
        check_all("R6 bins zero after clear");

        // Saturation
        for (int k = 0; k < MAXC + 45; k++) send(6);
        send(7);
        send(6);
        send(6);
        idle(4);
        read_bin(6, v);
        check("R5 saturated bin", v, MAXC);
        read_bin(7, v);
        check("R5 neighbour bin", v, 1);

        // Pseudo-random stream with long runs and gaps
        lfsr = 16'hACE1;
        cur  = 5;
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) cur = int'(lfsr[7:4]);
            if (lfsr[10:9] != 2'd0) send(cur);
            else idle(1);
        end
        check_all("R3 random stream");

        // Distance-2 repeats after a clear
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        wait_walk(n);
        for (int b = 0; b < NB; b++) ref_cnt[b] = 0;
        for (int k = 0; k < 10; k++) begin
            send(1);
            send(8);
        end
        send(1);
        idle(1);
        send(1);
        check_all("R4 alternating pair");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule